// File: doc/BRIEF.md
# Raster Timing Generator with Colour-Path Lead

The block produces the timing for a raster display: horizontal and vertical sync, an active-low blank strobe, and the x/y position of the pixel being shown. A pixel source reads the coordinates and returns a 30-bit colour word in the same cycle. The block gates that word and passes it on as three 10-bit channels to an external video DAC.

The DAC registers colour and blank, so they reach the connector one pixel clock after the block drives them. The sync lines go from the block straight to the connector. To line the two up, the block drives colour and blank for a pixel one clock before it drives the sync levels for that same pixel. The coordinates follow the colour timeline, so a source with no latency needs no correction of its own.

All porch, pulse and active lengths are compile-time parameters. Each sync polarity is chosen by its own parameter.

Top module: `vga_raster_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, x and y are 0, blank_no is 1 (active) and both sync outputs are at their inactive level.
- R2: x advances by one every clock from 0 up to H_ACT+H_FP+H_SYNC+H_BP-1, then returns to 0. The defaults give a line of 800 clocks.
- R3: y changes only in the cycle after x holds its last value. At that point y advances by one, or returns to 0 when it was at V_ACT+V_FP+V_SYNC+V_BP-1. The defaults give a frame of 525 lines.
- R4: blank_no is 1 exactly when x < H_ACT and y < V_ACT. Otherwise it is 0, which covers the whole horizontal and vertical blanking interval.
- R5: red_o, green_o and blue_o carry pix_i[29:20], pix_i[19:10] and pix_i[9:0] in cycles where blank_no is 1. In cycles where blank_no is 0 they are all zero, whatever pix_i holds.
- R6: In each cycle, hsync_o shows the horizontal sync state of the coordinates that were presented one cycle earlier. The pulse is active while that earlier x lies in [H_ACT+H_FP, H_ACT+H_FP+H_SYNC-1]. Each line's order is therefore active, front porch, sync, back porch.
- R7: In each cycle, vsync_o shows the vertical sync state of the y presented one cycle earlier. The pulse is active while that earlier y lies in [V_ACT+V_FP, V_ACT+V_FP+V_SYNC-1].
- R8: HS_ACTIVE_HIGH and VS_ACTIVE_HIGH select the active level of each sync. With the value 0 (the default) the active level is logic 0. With the value 1 the output is the exact complement of the value-0 output.
- R9: Delay colour and blank by one register to model the DAC. The delayed values then describe the same pixel as the undelayed sync outputs in the same cycle. As a result, the delayed blank is 0 in every cycle where either sync is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 3*COLOR_W | Colour from the pixel source: R in the top field, then G, then B |
| hsync_o | output | 1 | Horizontal sync, wired straight to the connector |
| vsync_o | output | 1 | Vertical sync, wired straight to the connector |
| blank_no | output | 1 | Blank to the DAC, 0 during blanking |
| red_o | output | COLOR_W | Red channel to the DAC |
| green_o | output | COLOR_W | Green channel to the DAC |
| blue_o | output | COLOR_W | Blue channel to the DAC |
| x_o | output | XW | Column of the pixel whose colour is driven this cycle |
| y_o | output | YW | Row of the pixel whose colour is driven this cycle |

## Verification
The bound checker tests every cycle that the counters step and wrap, that y moves only at the end of a line, and that blank agrees with the coordinates. It also checks that each sync level follows the coordinates of the previous cycle, which is the one-clock lead itself. Only the bench scenarios can show the connector-level view. There, a modelled DAC register delays colour and blank, and the bench compares the result with the undelayed syncs across two whole frames. The bench scenarios also cover colour gating against a changing pixel stream, the complemented output of an active-high instance, and recovery from a reset asserted mid-frame.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;

    // Registered state of the top level that sits outside the counters.
    typedef struct packed {
        logic vis;   // position now presented is visible
    } raster_vis_t;

    // Total span of one axis in clocks or lines.
    function automatic int axis_total(input int act, input int fp, input int syn, input int bp);
        return act + fp + syn + bp;
    endfunction

endpackage

// File: rtl/raster_axis_counter.sv
module raster_axis_counter #(
    parameter int ACT   = 640,
    parameter int FP    = 16,
    parameter int SYN   = 96,
    parameter int BP    = 48,
    localparam int TOTAL = ACT + FP + SYN + BP,
    localparam int W     = $clog2(TOTAL)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         step_i,
    output logic [W-1:0] pos_o,
    output logic         sync_now_o,
    output logic         vis_next_o
);

    localparam logic [W-1:0] LAST    = W'(TOTAL - 1);
    localparam logic [W-1:0] VIS_END = W'(ACT);
    localparam logic [W-1:0] SYN_LO  = W'(ACT + FP);
    localparam logic [W-1:0] SYN_HI  = W'(ACT + FP + SYN - 1);

    typedef struct packed {
        logic [W-1:0] pos;
    } axis_t;

    axis_t axis_d, axis_q;

    always_comb begin
        axis_d = axis_q;
        if (step_i) begin
            if (axis_q.pos == LAST) begin
                axis_d.pos = '0;
            end else begin
                axis_d.pos = axis_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            axis_q <= '0;
        end else begin
            axis_q <= axis_d;
        end
    end

    assign pos_o      = axis_q.pos;
    assign sync_now_o = (axis_q.pos >= SYN_LO) && (axis_q.pos <= SYN_HI);
    assign vis_next_o = (axis_d.pos < VIS_END);

endmodule

// File: rtl/raster_sync_out.sv
module raster_sync_out #(
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    output logic level_o
);

    typedef struct packed {
        logic on;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.on = hit_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    generate
        if (ACTIVE_HIGH) begin : g_high
            assign level_o = sync_q.on;
        end else begin : g_low
            assign level_o = ~sync_q.on;
        end
    endgenerate

endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
    import vga_raster_pkg::*;
#(
    parameter int H_ACT   = 640,
    parameter int H_FP    = 16,
    parameter int H_SYNC  = 96,
    parameter int H_BP    = 48,
    parameter int V_ACT   = 480,
    parameter int V_FP    = 10,
    parameter int V_SYNC  = 2,
    parameter int V_BP    = 33,
    parameter bit HS_ACTIVE_HIGH = 1'b0,
    parameter bit VS_ACTIVE_HIGH = 1'b0,
    parameter int COLOR_W = 10,
    localparam int H_TOT  = H_ACT + H_FP + H_SYNC + H_BP,
    localparam int V_TOT  = V_ACT + V_FP + V_SYNC + V_BP,
    localparam int XW     = $clog2(H_TOT),
    localparam int YW     = $clog2(V_TOT)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [3*COLOR_W-1:0] pix_i,
    output logic                 hsync_o,
    output logic                 vsync_o,
    output logic                 blank_no,
    output logic [COLOR_W-1:0]   red_o,
    output logic [COLOR_W-1:0]   green_o,
    output logic [COLOR_W-1:0]   blue_o,
    output logic [XW-1:0]        x_o,
    output logic [YW-1:0]        y_o
);

    localparam logic [XW-1:0] X_LAST = XW'(axis_total(H_ACT, H_FP, H_SYNC, H_BP) - 1);

    logic h_sync_now, h_vis_next;
    logic v_sync_now, v_vis_next;
    logic line_end;

    assign line_end = (x_o == X_LAST);

    raster_axis_counter #(
        .ACT (H_ACT),
        .FP  (H_FP),
        .SYN (H_SYNC),
        .BP  (H_BP)
    ) u_hcnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (1'b1),
        .pos_o      (x_o),
        .sync_now_o (h_sync_now),
        .vis_next_o (h_vis_next)
    );

    raster_axis_counter #(
        .ACT (V_ACT),
        .FP  (V_FP),
        .SYN (V_SYNC),
        .BP  (V_BP)
    ) u_vcnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (line_end),
        .pos_o      (y_o),
        .sync_now_o (v_sync_now),
        .vis_next_o (v_vis_next)
    );

    // Sync registers take the current position: they lag colour by one clock.
    raster_sync_out #(.ACTIVE_HIGH(HS_ACTIVE_HIGH)) u_hsync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hit_i   (h_sync_now),
        .level_o (hsync_o)
    );

    raster_sync_out #(.ACTIVE_HIGH(VS_ACTIVE_HIGH)) u_vsync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hit_i   (v_sync_now),
        .level_o (vsync_o)
    );

    // Visibility register takes the next position: it matches the coordinates.
    raster_vis_t vis_d, vis_q;

    always_comb begin
        vis_d     = vis_q;
        vis_d.vis = h_vis_next && v_vis_next;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vis_q <= '{vis: 1'b1};
        end else begin
            vis_q <= vis_d;
        end
    end

    assign blank_no = vis_q.vis;
    assign red_o    = vis_q.vis ? pix_i[3*COLOR_W-1:2*COLOR_W] : '0;
    assign green_o  = vis_q.vis ? pix_i[2*COLOR_W-1:COLOR_W]   : '0;
    assign blue_o   = vis_q.vis ? pix_i[COLOR_W-1:0]           : '0;

endmodule

// File: rtl/vga_raster_chk.sv
module vga_raster_chk #(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter bit HS_ACTIVE_HIGH = 1'b0,
    parameter bit VS_ACTIVE_HIGH = 1'b0,
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP,
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP,
    localparam int XW    = $clog2(H_TOT),
    localparam int YW    = $clog2(V_TOT)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [XW-1:0] x_o,
    input logic [YW-1:0] y_o,
    input logic          blank_no,
    input logic          hsync_o,
    input logic          vsync_o
);

    localparam logic [XW-1:0] XL    = XW'(H_TOT - 1);
    localparam logic [YW-1:0] YL    = YW'(V_TOT - 1);
    localparam logic [XW-1:0] XVIS  = XW'(H_ACT);
    localparam logic [YW-1:0] YVIS  = YW'(V_ACT);
    localparam logic [XW-1:0] XS_LO = XW'(H_ACT + H_FP);
    localparam logic [XW-1:0] XS_HI = XW'(H_ACT + H_FP + H_SYNC - 1);
    localparam logic [YW-1:0] YS_LO = YW'(V_ACT + V_FP);
    localparam logic [YW-1:0] YS_HI = YW'(V_ACT + V_FP + V_SYNC - 1);
    localparam logic HS_ON = HS_ACTIVE_HIGH;
    localparam logic VS_ON = VS_ACTIVE_HIGH;

    p_x_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_o != XL) |=> (x_o == $past(x_o) + 1'b1));

    p_x_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_o == XL) |=> (x_o == '0));

    p_y_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_o != XL) |=> $stable(y_o));

    p_y_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_o == XL && y_o != YL) |=> (y_o == $past(y_o) + 1'b1));

    p_y_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_o == XL && y_o == YL) |=> (y_o == '0));

    p_blank_map_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blank_no == ((x_o < XVIS) && (y_o < YVIS)));

    p_hs_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (x_o >= XS_LO && x_o <= XS_HI) |=> (hsync_o == HS_ON));

    p_hs_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(x_o >= XS_LO && x_o <= XS_HI) |=> (hsync_o != HS_ON));

    p_vs_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (y_o >= YS_LO && y_o <= YS_HI) |=> (vsync_o == VS_ON));

    p_vs_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(y_o >= YS_LO && y_o <= YS_HI) |=> (vsync_o != VS_ON));

endmodule

bind vga_raster_gen vga_raster_chk #(
    .H_ACT (H_ACT), .H_FP (H_FP), .H_SYNC (H_SYNC), .H_BP (H_BP),
    .V_ACT (V_ACT), .V_FP (V_FP), .V_SYNC (V_SYNC), .V_BP (V_BP),
    .HS_ACTIVE_HIGH (HS_ACTIVE_HIGH), .VS_ACTIVE_HIGH (VS_ACTIVE_HIGH)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .x_o      (x_o),
    .y_o      (y_o),
    .blank_no (blank_no),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o)
);

// File: tb/tb_vga_raster_gen.sv
module tb_vga_raster_gen;

    localparam int CLK_PERIOD = 10;
    localparam int HA = 8, HF = 2, HS = 3, HB = 2, HT = 15;
    localparam int VA = 4, VF = 1, VS = 2, VB = 2, VT = 9;
    localparam int FRAME = HT * VT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] pix = '0;

    logic       hs, vs, bn, hs2, vs2, bn2;
    logic [9:0] r, g, b, r2, g2, b2;
    logic [3:0] x, y, x2, y2;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vga_raster_gen #(
        .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .pix_i(pix),
        .hsync_o(hs), .vsync_o(vs), .blank_no(bn),
        .red_o(r), .green_o(g), .blue_o(b), .x_o(x), .y_o(y)
    );

    vga_raster_gen #(
        .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
        .HS_ACTIVE_HIGH(1'b1), .VS_ACTIVE_HIGH(1'b1)
    ) dut_pol (
        .clk_i(clk), .rst_ni(rst_n), .pix_i(pix),
        .hsync_o(hs2), .vsync_o(vs2), .blank_no(bn2),
        .red_o(r2), .green_o(g2), .blue_o(b2), .x_o(x2), .y_o(y2)
    );

    // Model of the DAC's input register.
    logic       dac_bn;
    logic [9:0] dac_r, dac_g, dac_b;
    always_ff @(posedge clk) begin
        dac_bn <= bn;
        dac_r  <= r;
        dac_g  <= g;
        dac_b  <= b;
    end

    typedef struct packed {
        logic [15:0] k;
        logic [3:0]  ex;
        logic [3:0]  ey;
        logic        ebn;
        logic        ehs;
        logic        evs;
    } probe_t;

    // Hand-worked probe points (active-low syncs).
    localparam probe_t PROBES [14] = '{
        '{16'd0,   4'd0,  4'd0, 1'b1, 1'b1, 1'b1},
        '{16'd7,   4'd7,  4'd0, 1'b1, 1'b1, 1'b1},
        '{16'd8,   4'd8,  4'd0, 1'b0, 1'b1, 1'b1},
        '{16'd10,  4'd10, 4'd0, 1'b0, 1'b1, 1'b1},
        '{16'd11,  4'd11, 4'd0, 1'b0, 1'b0, 1'b1},
        '{16'd13,  4'd13, 4'd0, 1'b0, 1'b0, 1'b1},
        '{16'd14,  4'd14, 4'd0, 1'b0, 1'b1, 1'b1},
        '{16'd15,  4'd0,  4'd1, 1'b1, 1'b1, 1'b1},
        '{16'd60,  4'd0,  4'd4, 1'b0, 1'b1, 1'b1},
        '{16'd75,  4'd0,  4'd5, 1'b0, 1'b1, 1'b1},
        '{16'd76,  4'd1,  4'd5, 1'b0, 1'b1, 1'b0},
        '{16'd105, 4'd0,  4'd7, 1'b0, 1'b1, 1'b0},
        '{16'd106, 4'd1,  4'd7, 1'b0, 1'b1, 1'b1},
        '{16'd135, 4'd0,  4'd0, 1'b1, 1'b1, 1'b1}
    };

    function automatic int xo(input int k); return k % HT; endfunction
    function automatic int yo(input int k); return (k / HT) % VT; endfunction
    function automatic logic vis(input int k);
        return (xo(k) < HA) && (yo(k) < VA);
    endfunction
    function automatic logic hs_lvl(input int k);
        if (k == 0) return 1'b1;
        return !(xo(k-1) >= HA + HF && xo(k-1) < HA + HF + HS);
    endfunction
    function automatic logic vs_lvl(input int k);
        if (k == 0) return 1'b1;
        return !(yo(k-1) >= VA + VF && yo(k-1) < VA + VF + VS);
    endfunction
    function automatic logic [29:0] pix_of(input int k);
        return {10'(k*3 + 1), 10'(k*5 + 2), 10'(k*7 + 3)};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values held during reset
        #1;
        check(x == 0 && y == 0, "R1 coords in reset", {x, y}, 0);
        check(bn == 1'b1 && hs == 1'b1 && vs == 1'b1, "R1 outputs in reset", {bn, hs, vs}, 7);
        rst_n = 1'b1;

        for (int k = 0; k <= 2 * FRAME + 2; k++) begin
            logic [29:0] p;
            p   = pix_of(k);
            pix = p;
            #1;
            // R2 / R3: coordinates
            check(x == 4'(xo(k)), "R2 x", x, xo(k));
            check(y == 4'(yo(k)), "R3 y", y, yo(k));
            // R4: blank
            check(bn == vis(k), "R4 blank", bn, vis(k));
            // R5: colour gating
            if (vis(k))
                check({r, g, b} == p, "R5 colour pass", {r, g, b}, p);
            else
                check({r, g, b} == 30'd0, "R5 colour zero in blank", {r, g, b}, 0);
            // R6 / R7: sync lags coordinates by one
            check(hs == hs_lvl(k), "R6 hsync", hs, hs_lvl(k));
            check(vs == vs_lvl(k), "R7 vsync", vs, vs_lvl(k));
            // R8: active-high instance is the complement
            check(hs2 == ~hs && vs2 == ~vs, "R8 polarity", {hs2, vs2}, {~hs, ~vs});
            // R9: DAC-delayed colour and blank line up with undelayed sync
            if (k >= 1) begin
                logic [29:0] pe;
                pe = vis(k-1) ? pix_of(k-1) : 30'd0;
                check(dac_bn == vis(k-1), "R9 delayed blank", dac_bn, vis(k-1));
                check({dac_r, dac_g, dac_b} == pe, "R9 delayed colour", {dac_r, dac_g, dac_b}, pe);
                if (!hs || !vs)
                    check(dac_bn == 1'b0, "R9 blank during sync", dac_bn, 0);
            end
            // Probe table (R2, R4, R6, R7)
            for (int i = 0; i < 14; i++) begin
                if (int'(PROBES[i].k) == k) begin
                    check({x, y, bn, hs, vs} ==
                          {PROBES[i].ex, PROBES[i].ey, PROBES[i].ebn, PROBES[i].ehs, PROBES[i].evs},
                          "R6 R7 probe", {x, y, bn, hs, vs},
                          {PROBES[i].ex, PROBES[i].ey, PROBES[i].ebn, PROBES[i].ehs, PROBES[i].evs});
                end
            end
            @(negedge clk);
        end

        // Directed: walk into a vertical sync pulse, then reset mid-frame (R1)
        while (!(vs == 1'b0 && hs == 1'b0)) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(x == 0 && y == 0, "R1 async reset coords", {x, y}, 0);
        check(hs == 1'b1 && vs == 1'b1 && hs2 == 1'b0 && vs2 == 1'b0,
              "R1 R8 syncs inactive in reset", {hs, vs, hs2, vs2}, 4'b1100);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(x == 0 && y == 0 && bn == 1'b1, "R1 first cycle after reset", {x, y, bn}, 1);
        check(hs == 1'b1 && vs == 1'b1, "R1 syncs after reset", {hs, vs}, 3);
        @(negedge clk);
        #1;
        check(x == 1 && y == 0, "R2 restart step", {x, y}, 16);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule